// File: doc/BRIEF.md
# Vectorised Condition-Field Register File

This block stores 128 condition fields of four flags each (less-than, greater-than, equal, summary-overflow). Software-visible operations reach the same storage three ways. Whole fields are read and written by a 7-bit field number. Single flags are read and written by a 9-bit bit number. Eight adjacent fields read out together as one 32-bit condition register, through a 4-bit register number.

A fourth port serves vector loops that record a co-result per element. The issuing logic supplies a base field number and an element index. The block writes the element's four flags into field base+index, so consecutive elements land in consecutive whole fields. A target past field 127 is dropped rather than wrapped, and the block raises a one-cycle error pulse.

All three read ports are combinational on the stored state. Writes take effect on the rising clock edge. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `cfr_file`

## Requirements
- R1: After reset every field holds 4'b0000, so all sixteen register reads return 32'h0.
- R2: A field write with `fw_en` stores `fw_data` in field `fw_idx`. The value appears on `fr_data` when `fr_idx` selects that field, in the cycle after the write edge.
- R3: `rr_data` for register number k carries field 8k+j in bits [31-4j:28-4j], so field 8k sits in the most significant nibble.
- R4: A bit number splits into a field number (upper 7 bits) and a flag position (lower 2 bits). Position 0 is LT, 1 is GT, 2 is EQ and 3 is SO, and each position equals the bit position inside the field. `br_data` returns that flag.
- R5: A bit write with `bw_en` changes only the addressed flag. The other three flags of that field and all other fields are unchanged.
- R6: A vector write with `vw_en` stores `vw_data` in field `vw_base + vw_elem`.
- R7: When `vw_base + vw_elem` exceeds 127, no field changes (no wrap to low fields). `oor_err` is high for exactly the one cycle after that write edge.
- R8: When a field write and a bit write address the same field in one cycle, the field takes `fw_data` with the addressed flag replaced by `bw_data`.
- R9: When a vector write and a field write target the same field, the field write wins. When a vector write and a bit write target the same field, the bit write is applied on top of the vector data.
- R10: `oor_err` stays low in every cycle that does not follow an out-of-range vector write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fw_en | input | 1 | Field write enable |
| fw_idx | input | 7 | Field write number |
| fw_data | input | 4 | Field write value |
| fr_idx | input | 7 | Field read number |
| fr_data | output | 4 | Field read value |
| bw_en | input | 1 | Bit write enable |
| bw_idx | input | 9 | Bit write number (field, flag) |
| bw_data | input | 1 | Bit write value |
| br_idx | input | 9 | Bit read number |
| br_data | output | 1 | Bit read value |
| rr_idx | input | 4 | Register read number |
| rr_data | output | 32 | Packed eight-field register |
| vw_en | input | 1 | Vector co-result write enable |
| vw_base | input | 7 | Vector base field |
| vw_elem | input | 7 | Element index |
| vw_data | input | 4 | Co-result flags |
| oor_err | output | 1 | Out-of-range vector write pulse |

## Verification
The hardest situations to reach from the ports are the collisions: two or three write ports landing on one field in the same edge, and a vector target just past the last field. Just past the last field, a wrapped address would silently hit field 0. The bench drives those collisions directly with chosen flag patterns, so each port's contribution is distinguishable bit by bit. It sends vector targets at exactly 127, 128 and the maximum sum. After every out-of-range attempt it sweeps all sixteen registers, so any write that slipped through is caught wherever it landed.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int FLAG_W   = 4;
  localparam int FLAG_LT  = 0;
  localparam int FLAG_GT  = 1;
  localparam int FLAG_EQ  = 2;
  localparam int FLAG_SO  = 3;
  typedef logic [FLAG_W-1:0] cfield_t;
endpackage

// File: rtl/cfr_wr_merge.sv
module cfr_wr_merge
  import cfr_pkg::*;
#(
  parameter int NF     = 128,
  parameter int FIDX_W = $clog2(NF),
  parameter int POS_W  = $clog2(FLAG_W)
) (
  input  logic [NF*FLAG_W-1:0] cur,
  input  logic                 vec_v,
  input  logic [FIDX_W-1:0]    vec_tgt,
  input  cfield_t              vec_d,
  input  logic                 fld_v,
  input  logic [FIDX_W-1:0]    fld_tgt,
  input  cfield_t              fld_d,
  input  logic                 bit_v,
  input  logic [FIDX_W-1:0]    bit_tgt,
  input  logic [POS_W-1:0]     bit_pos,
  input  logic                 bit_d,
  output logic [NF*FLAG_W-1:0] nxt,
  output logic [NF-1:0]        en
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic    hit_v, hit_f, hit_b;
    cfield_t val;

    assign hit_v = vec_v && (vec_tgt == FIDX_W'(i));
    assign hit_f = fld_v && (fld_tgt == FIDX_W'(i));
    assign hit_b = bit_v && (bit_tgt == FIDX_W'(i));

    // precedence: vector < field < bit
    always_comb begin
      val = cur[i*FLAG_W +: FLAG_W];
      if (hit_v) val = vec_d;
      if (hit_f) val = fld_d;
      if (hit_b) val[bit_pos] = bit_d;
    end

    assign nxt[i*FLAG_W +: FLAG_W] = val;
    assign en[i] = hit_v | hit_f | hit_b;
  end
endmodule

// File: rtl/cfr_store.sv
module cfr_store
  import cfr_pkg::*;
#(
  parameter int NF = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NF-1:0]        en,
  input  logic [NF*FLAG_W-1:0] nxt,
  output logic [NF*FLAG_W-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i*FLAG_W +: FLAG_W] <= '0;
      else if (en[i]) q[i*FLAG_W +: FLAG_W] <= nxt[i*FLAG_W +: FLAG_W];
    end
  end
endmodule

// File: rtl/cfr_read.sv
module cfr_read
  import cfr_pkg::*;
#(
  parameter int NF     = 128,
  parameter int FPR    = 8,
  parameter int FIDX_W = $clog2(NF),
  parameter int SUB_W  = $clog2(FPR),
  parameter int RIDX_W = FIDX_W - SUB_W,
  parameter int POS_W  = $clog2(FLAG_W),
  parameter int REG_W  = FPR * FLAG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NF*FLAG_W-1:0]   q,
  input  logic [FIDX_W-1:0]      fr_idx,
  input  logic [FIDX_W+POS_W-1:0] br_idx,
  input  logic [RIDX_W-1:0]      rr_idx,
  output cfield_t                fr_data,
  output logic                   br_data,
  output logic [REG_W-1:0]       rr_data
);
  cfield_t bfield;

  assign fr_data = q[fr_idx*FLAG_W +: FLAG_W];
  assign bfield  = q[br_idx[FIDX_W+POS_W-1:POS_W]*FLAG_W +: FLAG_W];
  assign br_data = bfield[br_idx[POS_W-1:0]];

  for (genvar j = 0; j < FPR; j++) begin : g_pack
    logic [FIDX_W-1:0] src;
    assign src = {rr_idx, SUB_W'(j)};
    assign rr_data[REG_W-1-j*FLAG_W -: FLAG_W] = q[src*FLAG_W +: FLAG_W];
  end

  // R3: the packed view and the field view agree on a shared field
  a_r3_pack_order: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_idx[FIDX_W-1:SUB_W] == rr_idx) |->
      (rr_data[REG_W-1-fr_idx[SUB_W-1:0]*FLAG_W -: FLAG_W] == fr_data));

  // R4: a bit read is the selected flag of the selected field
  a_r4_bit_view: assert property (@(posedge clk) disable iff (!rst_n)
    (br_idx[FIDX_W+POS_W-1:POS_W] == fr_idx) |->
      (br_data == fr_data[br_idx[POS_W-1:0]]));
endmodule

// File: rtl/cfr_file.sv
module cfr_file
  import cfr_pkg::*;
#(
  parameter int NF     = 128,
  parameter int FPR    = 8,
  parameter int FIDX_W = $clog2(NF),
  parameter int SUB_W  = $clog2(FPR),
  parameter int RIDX_W = FIDX_W - SUB_W,
  parameter int POS_W  = $clog2(FLAG_W),
  parameter int BIDX_W = FIDX_W + POS_W,
  parameter int REG_W  = FPR * FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_en,
  input  logic [FIDX_W-1:0] fw_idx,
  input  logic [FLAG_W-1:0] fw_data,
  input  logic [FIDX_W-1:0] fr_idx,
  output logic [FLAG_W-1:0] fr_data,
  input  logic              bw_en,
  input  logic [BIDX_W-1:0] bw_idx,
  input  logic              bw_data,
  input  logic [BIDX_W-1:0] br_idx,
  output logic              br_data,
  input  logic [RIDX_W-1:0] rr_idx,
  output logic [REG_W-1:0]  rr_data,
  input  logic              vw_en,
  input  logic [FIDX_W-1:0] vw_base,
  input  logic [FIDX_W-1:0] vw_elem,
  input  logic [FLAG_W-1:0] vw_data,
  output logic              oor_err
);
  logic [1:0]              rst_sync_q;
  logic                    rst_s;
  logic [FIDX_W:0]         vsum;
  logic                    voor, vok;
  logic                    err_d, err_q;
  logic [NF*FLAG_W-1:0]    q, nxt;
  logic [NF-1:0]           en;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // vector target: one extra bit catches sums past the last field
  always_comb begin
    vsum  = {1'b0, vw_base} + {1'b0, vw_elem};
    voor  = (vsum > (FIDX_W+1)'(NF-1));
    vok   = vw_en && !voor;
    err_d = vw_en && voor;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign oor_err = err_q;

  cfr_wr_merge #(.NF(NF)) u_merge (
    .cur     (q),
    .vec_v   (vok),
    .vec_tgt (vsum[FIDX_W-1:0]),
    .vec_d   (vw_data),
    .fld_v   (fw_en),
    .fld_tgt (fw_idx),
    .fld_d   (fw_data),
    .bit_v   (bw_en),
    .bit_tgt (bw_idx[BIDX_W-1:POS_W]),
    .bit_pos (bw_idx[POS_W-1:0]),
    .bit_d   (bw_data),
    .nxt     (nxt),
    .en      (en)
  );

  cfr_store #(.NF(NF)) u_store (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (en),
    .nxt   (nxt),
    .q     (q)
  );

  cfr_read #(.NF(NF), .FPR(FPR)) u_read (
    .clk     (clk),
    .rst_n   (rst_s),
    .q       (q),
    .fr_idx  (fr_idx),
    .br_idx  (br_idx),
    .rr_idx  (rr_idx),
    .fr_data (fr_data),
    .br_data (br_data),
    .rr_data (rr_data)
  );

  // shadow of a lone bit write, kept only for the R5 check
  logic              bchk_v;
  logic [FIDX_W-1:0] bchk_f;
  logic [POS_W-1:0]  bchk_b;
  logic              bchk_d;
  cfield_t           bchk_old;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bchk_v <= 1'b0; bchk_f <= '0; bchk_b <= '0; bchk_d <= 1'b0; bchk_old <= '0;
    end else begin
      bchk_v   <= bw_en && !fw_en && !vw_en;
      bchk_f   <= bw_idx[BIDX_W-1:POS_W];
      bchk_b   <= bw_idx[POS_W-1:0];
      bchk_d   <= bw_data;
      bchk_old <= q[bw_idx[BIDX_W-1:POS_W]*FLAG_W +: FLAG_W];
    end
  end

  // R5: a lone bit write sets its flag and leaves the other three
  a_r5_bit_only: assert property (@(posedge clk) disable iff (!rst_s)
    bchk_v |-> (((q[bchk_f*FLAG_W +: FLAG_W] ^ bchk_old) & ~(cfield_t'(1) << bchk_b)) == '0)
               && (q[bchk_f*FLAG_W + bchk_b] == bchk_d));

  // R6: an in-range lone vector write lands at base+elem
  a_r6_vec_lands: assert property (@(posedge clk) disable iff (!rst_s)
    (vw_en && !voor && !fw_en && !bw_en) |=>
      (q[$past(vsum[FIDX_W-1:0])*FLAG_W +: FLAG_W] == $past(vw_data)));

  // R7: an out-of-range vector write alone changes nothing and flags an error
  a_r7_oor_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (vw_en && voor && !fw_en && !bw_en) |=> ($stable(q) && oor_err));

  // R10: no error pulse without a preceding vector write
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_s)
    !vw_en |=> !oor_err);
endmodule

// File: tb/sim_cfr_file.sv
module sim_cfr_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fw_en, bw_en, vw_en, bw_data;
  logic [6:0]  fw_idx, fr_idx, vw_base, vw_elem;
  logic [3:0]  fw_data, vw_data, fr_data;
  logic [8:0]  bw_idx, br_idx;
  logic        br_data, oor_err;
  logic [3:0]  rr_idx;
  logic [31:0] rr_data;

  int total = 0;
  int bad   = 0;
  logic [3:0] m [128];

  always #10 clk = ~clk;

  cfr_file u0 (
    .clk(clk), .rst_n(rst_n),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_data(fw_data),
    .fr_idx(fr_idx), .fr_data(fr_data),
    .bw_en(bw_en), .bw_idx(bw_idx), .bw_data(bw_data),
    .br_idx(br_idx), .br_data(br_data),
    .rr_idx(rr_idx), .rr_data(rr_data),
    .vw_en(vw_en), .vw_base(vw_base), .vw_elem(vw_elem), .vw_data(vw_data),
    .oor_err(oor_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input int k);
    logic [31:0] r;
    for (int j = 0; j < 8; j++) r[31-4*j -: 4] = m[8*k+j];
    return r;
  endfunction

  task automatic idle();
    fw_en = 0; bw_en = 0; vw_en = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic sweep_regs(input string req);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); rr_idx = 4'(k); #2;
      check(req, rr_data, exp_reg(k));
    end
  endtask

  task automatic fld_check(input string req, input int f);
    fr_idx = 7'(f); #2;
    check(req, {28'h0, fr_data}, {28'h0, m[f]});
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    fw_idx = 0; fw_data = 0; fr_idx = 0; bw_idx = 0; bw_data = 0; br_idx = 0;
    rr_idx = 0; vw_base = 0; vw_elem = 0; vw_data = 0;
    for (int i = 0; i < 128; i++) m[i] = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: everything cleared
    sweep_regs("R1");
    #2 check("R10", {31'h0, oor_err}, 32'h0);

    // R2 / R3: fill every field, read back by field and packed
    for (int f = 0; f < 128; f++) begin
      @(negedge clk);
      fw_en = 1; fw_idx = 7'(f); fw_data = 4'((f*7 + 3) % 16); m[f] = fw_data;
      tick();
      fld_check("R2", f);
    end
    sweep_regs("R3");

    // R4: every flag of every field through the bit port
    for (int b = 0; b < 512; b++) begin
      @(negedge clk); br_idx = 9'(b); #2;
      check("R4", {31'h0, br_data}, {31'h0, m[b/4][b%4]});
    end

    // R5: lone bit writes flip one flag
    for (int f = 0; f < 128; f += 5) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        bw_en = 1; bw_idx = 9'(f*4 + p); bw_data = ~m[f][p]; m[f][p] = bw_data;
        tick();
        fld_check("R5", f);
      end
    end
    sweep_regs("R5");

    // R6: vector writes step through whole fields
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      vw_en = 1; vw_base = 7'd37; vw_elem = 7'(e); vw_data = 4'(15 - e); m[37+e] = vw_data;
      tick();
      fld_check("R6", 37 + e);
      check("R10", {31'h0, oor_err}, 32'h0);
    end
    @(negedge clk);
    vw_en = 1; vw_base = 7'd120; vw_elem = 7'd7; vw_data = 4'h6; m[127] = 4'h6;
    tick();
    fld_check("R6", 127);
    check("R10", {31'h0, oor_err}, 32'h0);

    // R7: targets past the last field
    @(negedge clk);
    vw_en = 1; vw_base = 7'd120; vw_elem = 7'd8; vw_data = ~m[0];
    tick();
    check("R7", {31'h0, oor_err}, 32'h1);
    @(negedge clk); #2;
    check("R7", {31'h0, oor_err}, 32'h0);
    sweep_regs("R7");
    @(negedge clk);
    vw_en = 1; vw_base = 7'd127; vw_elem = 7'd127; vw_data = ~m[126];
    tick();
    check("R7", {31'h0, oor_err}, 32'h1);
    sweep_regs("R7");

    // R8: field and bit write on the same field
    @(negedge clk);
    fw_en = 1; fw_idx = 7'd50; fw_data = 4'b1010;
    bw_en = 1; bw_idx = 9'(50*4 + 0); bw_data = 1'b1; m[50] = 4'b1011;
    tick();
    fld_check("R8", 50);
    @(negedge clk);
    fw_en = 1; fw_idx = 7'd51; fw_data = 4'b0110;
    bw_en = 1; bw_idx = 9'(51*4 + 1); bw_data = 1'b0; m[51] = 4'b0100;
    tick();
    fld_check("R8", 51);

    // R9: vector collides with field, then with bit
    @(negedge clk);
    vw_en = 1; vw_base = 7'd55; vw_elem = 7'd5; vw_data = 4'h5;
    fw_en = 1; fw_idx = 7'd60; fw_data = 4'h9; m[60] = 4'h9;
    tick();
    fld_check("R9", 60);
    @(negedge clk);
    vw_en = 1; vw_base = 7'd60; vw_elem = 7'd1; vw_data = 4'h0;
    bw_en = 1; bw_idx = 9'(61*4 + 3); bw_data = 1'b1; m[61] = 4'b1000;
    tick();
    fld_check("R9", 61);
    check("R10", {31'h0, oor_err}, 32'h0);
    sweep_regs("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule